// File: doc/BRIEF.md
# Next Instruction Address Unit

This block keeps the program counter of a small 32-bit load/store processor and works out, every time it is told to advance, which address the next instruction is fetched from. It looks at the instruction now being executed and at the two register operands already read for it. From these it picks one of four sources: the following word, an absolute jump target inside the current 256 MiB region, a register value, or a word-counted offset from the following word.

Besides the counter it reports whether the flow of control was redirected. For a call it raises a one-cycle request to write the return address into the link register. Instruction memory, the register file and the arithmetic unit sit outside the block. There are no exceptions, system calls or delay slots, so the address the block selects is the very next instruction to execute.

Top module: `fetch_addr_unit`

## Requirements
- R1: A synchronous active-high reset loads the counter with 0x00400000, and while reset holds, `taken` and `link_we` are 0.
- R2: While `adv` is 0 the counter keeps its value and `taken` and `link_we` stay 0, whatever the instruction.
- R3: An instruction that does not transfer control (any opcode in bits 31..26 other than 0/funct 8, 1, 2, 3, 4 or 5) advances the counter by 4, with `taken` 0.
- R4: Opcode 2 loads the counter with bits 31..28 of (counter+4), then instruction bits 25..0, then two zero bits, and drives `taken` to 1.
- R5: Opcode 3 jumps exactly as in R4. In the same cycle it drives `link_we` 1, `link_reg` 31 and `link_val` = counter+4, and `link_we` is 0 in every other cycle.
- R6: Opcode 0 with function bits 5..0 equal to 8 loads the counter with `rs_val` and drives `taken` 1. Opcode 0 with any other function code behaves as in R3.
- R7: Opcode 1 branches when bit 31 of `rs_val` is 1. The target is counter+4 plus the sign-extended bits 15..0 shifted left by 2.
- R8: Opcode 4 branches to the R7 target when `rs_val` equals `rt_val`.
- R9: Opcode 5 branches to the R7 target when `rs_val` differs from `rt_val`.
- R10: A branch whose condition fails advances the counter by 4, with `taken` 0.
- R11: A negative branch offset moves the counter backwards, with the target computed modulo 2^32.
- R12: The region bits of a jump come from counter+4, so a jump in the last word of a region lands in the next region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Execute the presented instruction and update the counter |
| instr | input | 32 | Instruction being executed |
| rs_val | input | 32 | Register value selected by bits 25..21 |
| rt_val | input | 32 | Register value selected by bits 20..16 |
| pc_q | output | 32 | Current program counter |
| taken | output | 1 | Control is redirected this cycle |
| link_we | output | 1 | Write request for the return address |
| link_reg | output | 5 | Destination register of the return address (31) |
| link_val | output | 32 | Return address, counter+4 |

## Verification
The properties assume that `instr`, `rs_val` and `rt_val` are steady and meaningful whenever `adv` is high at a clock edge. They also assume that the operand values belong to the instruction presented, since the block does no forwarding of its own. The stimulus changes the inputs only on falling edges and holds each instruction together with its operands for a whole cycle. It also places a held-off cycle, with a transfer instruction present and `adv` low, to show that nothing moves without the strobe.

// File: rtl/fau_pkg.sv
package fau_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_BNEG    = 6'd1;
    localparam logic [5:0] OPC_JUMP    = 6'd2;
    localparam logic [5:0] OPC_CALL    = 6'd3;
    localparam logic [5:0] OPC_BEQ     = 6'd4;
    localparam logic [5:0] OPC_BNE     = 6'd5;
    localparam logic [5:0] FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        FK_SEQ,
        FK_JUMP,
        FK_CALL,
        FK_JREG,
        FK_BNEG,
        FK_BEQ,
        FK_BNE
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e  kind;
        logic [25:0] jfield;
        logic [15:0] disp;
    } flow_ctl_t;

    function automatic logic is_branch(input flow_kind_e k);
        return (k == FK_BNEG) || (k == FK_BEQ) || (k == FK_BNE);
    endfunction

endpackage

// File: rtl/fau_decode.sv
module fau_decode
    import fau_pkg::*;
(
    input  logic [31:0] instr,
    output flow_ctl_t   ctl
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        ctl.jfield = instr[25:0];
        ctl.disp   = instr[15:0];
        unique case (opc)
            OPC_SPECIAL: ctl.kind = (fn == FN_JREG) ? FK_JREG : FK_SEQ;
            OPC_BNEG:    ctl.kind = FK_BNEG;
            OPC_JUMP:    ctl.kind = FK_JUMP;
            OPC_CALL:    ctl.kind = FK_CALL;
            OPC_BEQ:     ctl.kind = FK_BEQ;
            OPC_BNE:     ctl.kind = FK_BNE;
            default:     ctl.kind = FK_SEQ;
        endcase
    end
endmodule

// File: rtl/fau_cond.sv
module fau_cond
    import fau_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_kind_e       kind,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    output logic             cond_ok
);
    logic same;

    assign same = (a_val == b_val);

    always_comb begin
        unique case (kind)
            FK_BNEG: cond_ok = a_val[XLEN-1];
            FK_BEQ:  cond_ok = same;
            FK_BNE:  cond_ok = !same;
            default: cond_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fau_target.sv
module fau_target
    import fau_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int JBITS = 26,
    parameter int DBITS = 16
) (
    input  logic [XLEN-1:0] pc,
    input  flow_ctl_t       ctl,
    input  logic [XLEN-1:0] a_val,
    input  logic            cond_ok,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] nxt_pc,
    output logic            xfer
);
    localparam int REGION = XLEN - JBITS - 2;
    localparam int SEXT   = XLEN - DBITS - 2;

    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] br_disp;

    assign seq_pc   = pc + XLEN'(4);
    assign jump_tgt = {seq_pc[XLEN-1 -: REGION], ctl.jfield, 2'b00};
    assign br_disp  = {{SEXT{ctl.disp[DBITS-1]}}, ctl.disp, 2'b00};
    assign br_tgt   = seq_pc + br_disp;

    always_comb begin
        nxt_pc = seq_pc;
        xfer   = 1'b0;
        unique case (ctl.kind)
            FK_JUMP, FK_CALL: begin
                nxt_pc = jump_tgt;
                xfer   = 1'b1;
            end
            FK_JREG: begin
                nxt_pc = a_val;
                xfer   = 1'b1;
            end
            FK_BNEG, FK_BEQ, FK_BNE: begin
                if (cond_ok) begin
                    nxt_pc = br_tgt;
                    xfer   = 1'b1;
                end
            end
            default: begin
                nxt_pc = seq_pc;
                xfer   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
    import fau_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          RAW      = 5,
    parameter logic [31:0] RESET_PC = 32'h0040_0000,
    parameter int          LINK_IDX = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] pc_q,
    output logic            taken,
    output logic            link_we,
    output logic [RAW-1:0]  link_reg,
    output logic [XLEN-1:0] link_val
);
    localparam int JBITS = 26;
    localparam int DBITS = 16;

    flow_ctl_t       ctl;
    logic            cond_ok;
    logic            xfer;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] nxt_pc;

    fau_decode u_decode (
        .instr (instr),
        .ctl   (ctl)
    );

    fau_cond #(.XLEN(XLEN)) u_cond (
        .kind    (ctl.kind),
        .a_val   (rs_val),
        .b_val   (rt_val),
        .cond_ok (cond_ok)
    );

    fau_target #(.XLEN(XLEN), .JBITS(JBITS), .DBITS(DBITS)) u_target (
        .pc      (pc_q),
        .ctl     (ctl),
        .a_val   (rs_val),
        .cond_ok (cond_ok),
        .seq_pc  (seq_pc),
        .nxt_pc  (nxt_pc),
        .xfer    (xfer)
    );

    always_ff @(posedge clk) begin
        if (rst)      pc_q <= XLEN'(RESET_PC);
        else if (adv) pc_q <= nxt_pc;
    end

    assign taken    = adv && !rst && xfer;
    assign link_we  = adv && !rst && (ctl.kind == FK_CALL);
    assign link_reg = RAW'(LINK_IDX);
    assign link_val = seq_pc;

    // R2: without the strobe the counter does not move
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pc_q));

    // R2: a redirect or link request only occurs while advancing
    p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (taken || link_we) |-> adv);

    // R3 / R10: no redirect means the following word
    p_seq_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !taken) |=> pc_q == $past(pc_q) + XLEN'(4));

    // R5: a link request lands on the word address carried by the call
    p_call_r5: assert property (@(posedge clk) disable iff (rst)
        link_we |=> pc_q[JBITS+1:2] == $past(instr[JBITS-1:0]));

    // R6: register jump takes the rs operand
    p_jreg_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && instr[31:26] == OPC_SPECIAL && instr[5:0] == FN_JREG)
        |=> pc_q == $past(rs_val));

    // R8: equal operands always redirect on opcode 4
    p_beq_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && instr[31:26] == OPC_BEQ && rs_val == rt_val) |-> taken);

    // R9: equal operands never redirect on opcode 5
    p_bne_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && instr[31:26] == OPC_BNE && rs_val == rt_val) |-> !taken);

endmodule

// File: tb/fetch_addr_unit_tb.sv
module fetch_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        adv;
    logic [31:0] instr;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] pc_q;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_reg;
    logic [31:0] link_val;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_pc;

    always #2 clk = ~clk;

    fetch_addr_unit u_dut (
        .clk(clk), .rst(rst), .adv(adv), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc_q(pc_q), .taken(taken),
        .link_we(link_we), .link_reg(link_reg), .link_val(link_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [25:0] rest);
        return {op, rest};
    endfunction

    function automatic logic [31:0] br_tgt(input logic [31:0] pc, input logic [15:0] d);
        return pc + 32'd4 + {{14{d[15]}}, d, 2'b00};
    endfunction

    // drive one instruction, check same-cycle outputs, then the new counter
    task automatic step(input string tag, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] nxt,
                        input logic exp_taken, input logic exp_link);
        instr = ins; rs_val = a; rt_val = b; adv = 1'b1;
        #1;
        chk({tag, " taken"}, {31'd0, taken}, {31'd0, exp_taken});
        chk({tag, " link_we"}, {31'd0, link_we}, {31'd0, exp_link});
        if (exp_link) begin
            chk({tag, " link_reg"}, {27'd0, link_reg}, 32'd31);
            chk({tag, " link_val"}, link_val, exp_pc + 32'd4);
        end
        @(negedge clk);
        exp_pc = nxt;
        chk({tag, " pc"}, pc_q, exp_pc);
    endtask

    task automatic t_reset();
        rst = 1'b1; adv = 1'b1; instr = mk_i(6'd2, 26'h3); rs_val = 0; rt_val = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 taken in reset", {31'd0, taken}, 32'd0);
        chk("R1 link in reset", {31'd0, link_we}, 32'd0);
        chk("R1 reset pc", pc_q, 32'h0040_0000);
        rst = 1'b0; adv = 1'b0;
        @(negedge clk);
        exp_pc = 32'h0040_0000;
        chk("R1 pc after release", pc_q, exp_pc);
    endtask

    task automatic t_hold();
        adv = 1'b0; instr = mk_i(6'd3, 26'h12345); rs_val = 0; rt_val = 0;
        #1;
        chk("R2 taken held", {31'd0, taken}, 32'd0);
        chk("R2 link held", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        chk("R2 pc held", pc_q, exp_pc);
    endtask

    task automatic t_seq();
        step("R3 add", mk_i(6'd0, {5'd1, 5'd2, 5'd3, 5'd0, 6'd32}), 0, 0, exp_pc + 4, 0, 0);
        step("R3 addi", mk_i(6'd8, 26'h0000008), 0, 0, exp_pc + 4, 0, 0);
        step("R3 store", mk_i(6'd43, 26'h0000010), 0, 0, exp_pc + 4, 0, 0);
    endtask

    task automatic t_jreg();
        step("R6 funct 12 seq", mk_i(6'd0, 26'h000000C), 32'h1234_5678, 0, exp_pc + 4, 0, 0);
        step("R6 jr", mk_i(6'd0, {5'd31, 15'd0, 6'd8}), 32'h0FFF_FFF0, 0, 32'h0FFF_FFF0, 1, 0);
    endtask

    task automatic t_jump_region();
        step("R3 walk", 32'h0, 0, 0, exp_pc + 4, 0, 0);
        step("R3 walk", 32'h0, 0, 0, exp_pc + 4, 0, 0);
        step("R3 walk", 32'h0, 0, 0, exp_pc + 4, 0, 0);
        chk("R12 last word", pc_q, 32'h0FFF_FFFC);
        step("R12 R4 jump across", mk_i(6'd2, 26'h0000010), 0, 0, 32'h1000_0040, 1, 0);
    endtask

    task automatic t_call();
        step("R5 jal", mk_i(6'd3, 26'h0100000), 0, 0, 32'h1040_0000, 1, 1);
        step("R5 after jal", mk_i(6'd8, 26'h0), 0, 0, exp_pc + 4, 0, 0);
        step("R4 jump", mk_i(6'd2, 26'h0000100), 0, 0, 32'h1000_0400, 1, 0);
    endtask

    task automatic t_branches();
        step("R7 bneg taken", mk_i(6'd1, {5'd4, 5'd0, 16'd3}), 32'h8000_0000, 0,
             br_tgt(exp_pc, 16'd3), 1, 0);
        step("R10 bneg not", mk_i(6'd1, {5'd4, 5'd0, 16'd3}), 32'h7FFF_FFFF, 0, exp_pc + 4, 0, 0);
        step("R8 R11 beq back", mk_i(6'd4, {5'd4, 5'd5, 16'hFFFE}), 32'd77, 32'd77,
             br_tgt(exp_pc, 16'hFFFE), 1, 0);
        step("R10 beq not", mk_i(6'd4, {5'd4, 5'd5, 16'h0005}), 32'd77, 32'd78, exp_pc + 4, 0, 0);
        step("R9 bne taken", mk_i(6'd5, {5'd4, 5'd5, 16'h0010}), 32'd1, 32'd2,
             br_tgt(exp_pc, 16'h0010), 1, 0);
        step("R10 bne not", mk_i(6'd5, {5'd4, 5'd5, 16'h0010}), 32'd9, 32'd9, exp_pc + 4, 0, 0);
        step("R11 bne large back", mk_i(6'd5, {5'd4, 5'd5, 16'h8000}), 32'd1, 32'd0,
             br_tgt(exp_pc, 16'h8000), 1, 0);
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; adv = 1'b0; instr = 0; rs_val = 0; rt_val = 0; exp_pc = 0;
        @(negedge clk);
        t_reset();
        t_hold();
        t_seq();
        t_jreg();
        t_jump_region();
        t_call();
        t_hold();
        t_branches();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule